// File: doc/BRIEF.md
# Dual-Modulus Shift-Add Modular Multiplier

This block multiplies two 24-bit operand words and reduces the product modulo one of two lattice-cryptography primes. The choice is made per transaction by a scheme select. In the wide scheme, each word carries one 23-bit coefficient and the product is reduced modulo 8380417. In the narrow scheme, each word carries two independent 12-bit coefficients, and the two lane products are reduced modulo 3329 side by side.

Reduction uses no precomputed constants. The high part of the product is folded back onto the low part using the special binary form of each prime, 2^23 ≡ 2^13 − 1 for the wide prime and 2^12 ≡ 2^9 + 2^8 − 1 for the narrow one. This repeats until the value is small, and a short run of conditional subtractions then brings every lane into [0, q). The unit is fully pipelined over three stages (multiply, fold, correct), so it accepts one word per cycle in either scheme and may switch scheme on every cycle.

Top module: `dualq_modmul`

## Requirements
- R1: With `useNarrow` low, `result[22:0]` equals (`opA[22:0]` × `opB[22:0]`) mod 8380417 and `result[23]` is 0.
- R2: With `useNarrow` high, lane 0 is bits [11:0] and lane 1 is bits [23:12]; each result lane equals the product of the matching operand lanes mod 3329, with no carry or influence between lanes.
- R3: Every result lane is in [0, q) for its scheme when the operands are already reduced, including the edge operands 0 and q − 1.
- R4: `outValid` is high exactly three rising edges after `inValid` was sampled high, once for each accepted input, and the unit accepts an input on every cycle.
- R5: The scheme is captured with each input, so words of the two schemes may alternate on back-to-back cycles and each comes out reduced under its own scheme.
- R6: While reset is asserted, and right after it is released, `outValid` is 0 and `result` is 0.
- R7: While `outValid` is low, `result` keeps the last value that was delivered.
- R8: With `useNarrow` low, bit 23 of each operand has no effect on the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Operand words valid this cycle |
| useNarrow | input | 1 | 1: two 12-bit lanes mod 3329; 0: one 23-bit value mod 8380417 |
| opA | input | 24 | First operand word |
| opB | input | 24 | Second operand word |
| outValid | output | 1 | Result valid |
| result | output | 24 | Reduced product word |

## Verification
A stream of wide and narrow words is applied back to back with the scheme changing between neighbours. This separates a per-transaction scheme from one that is latched too early or too late. The operands include 0, 1, q − 1 squared and large mixed values. q − 1 squared yields 1 only if every fold and both correction steps are right, while asymmetric narrow lanes such as 3328 beside 0 expose any carry or swap between lanes. Directed cases measure the latency edge by edge, set operand bit 23 in the wide scheme to show that it is ignored, and watch the held result and reset clearing it.

// File: rtl/dualq_pkg.sv
package dualq_pkg;
  localparam int WORD_W     = 24;
  localparam int WIDE_W     = 23;
  localparam int LANE_W     = 12;
  localparam int LANES      = WORD_W / LANE_W;
  localparam int WIDE_PW    = 2 * WIDE_W;
  localparam int LANE_PW    = 2 * LANE_W;
  localparam int WIDE_FW    = WIDE_W + 2;
  localparam int LANE_FW    = LANE_W + 2;
  localparam int WIDE_Q     = 8380417;
  localparam int LANE_Q     = 3329;
  localparam int WIDE_FOLDS = 3;
  localparam int LANE_FOLDS = 5;
  localparam int FIX_STEPS  = 2;
  localparam int PIPE_DEPTH = 3;

  typedef struct packed {
    logic ldMul;
    logic ldFold;
    logic ldOut;
    logic narrowOut;
  } stageStrobe_t;

  // Fold the wide product: hi*2^23 + lo -> hi*2^13 - hi + lo + q (never negative).
  function automatic logic [WIDE_FW-1:0] foldWide(input logic [WIDE_PW-1:0] p);
    logic [47:0] x;
    logic [24:0] hi;
    x = {2'b0, p};
    for (int i = 0; i < WIDE_FOLDS; i++) begin
      hi = x[47:23];
      x = ({23'b0, hi} << 13) + {25'b0, x[22:0]} + 48'(WIDE_Q) - {23'b0, hi};
    end
    return x[WIDE_FW-1:0];
  endfunction

  // Fold one lane product: hi*2^12 + lo -> hi*(2^9 + 2^8 - 1) + lo.
  function automatic logic [LANE_FW-1:0] foldLane(input logic [LANE_PW-1:0] p);
    logic [23:0] x;
    logic [11:0] hi;
    x = p;
    for (int i = 0; i < LANE_FOLDS; i++) begin
      hi = x[23:12];
      x = ({12'b0, hi} << 9) + ({12'b0, hi} << 8) - {12'b0, hi} + {12'b0, x[11:0]};
    end
    return x[LANE_FW-1:0];
  endfunction

  function automatic logic [WIDE_W-1:0] fixWide(input logic [WIDE_FW-1:0] v);
    logic [WIDE_FW-1:0] x;
    x = v;
    for (int i = 0; i < FIX_STEPS; i++)
      if (x >= WIDE_FW'(WIDE_Q)) x = x - WIDE_FW'(WIDE_Q);
    return x[WIDE_W-1:0];
  endfunction

  function automatic logic [LANE_W-1:0] fixLane(input logic [LANE_FW-1:0] v);
    logic [LANE_FW-1:0] x;
    x = v;
    for (int i = 0; i < FIX_STEPS; i++)
      if (x >= LANE_FW'(LANE_Q)) x = x - LANE_FW'(LANE_Q);
    return x[LANE_W-1:0];
  endfunction
endpackage

// File: rtl/dualq_wide_reducer.sv
module dualq_wide_reducer
  import dualq_pkg::*;
(
  input  logic [WIDE_PW-1:0] prodIn,
  output logic [WIDE_FW-1:0] foldOut
);
  always_comb foldOut = foldWide(prodIn);
endmodule

// File: rtl/dualq_lane_reducer.sv
module dualq_lane_reducer
  import dualq_pkg::*;
(
  input  logic [LANE_PW-1:0] prodIn,
  output logic [LANE_FW-1:0] foldOut
);
  always_comb foldOut = foldLane(prodIn);
endmodule

// File: rtl/dualq_ctrl.sv
module dualq_ctrl
  import dualq_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inValid,
  input  logic         useNarrow,
  output stageStrobe_t strobe,
  output logic         outValid
);
  logic [PIPE_DEPTH-1:0] validPipe;
  logic [PIPE_DEPTH-2:0] narrowPipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      validPipe  <= '0;
      narrowPipe <= '0;
    end else begin
      validPipe  <= {validPipe[PIPE_DEPTH-2:0], inValid};
      narrowPipe <= {narrowPipe[PIPE_DEPTH-3:0], useNarrow && inValid};
    end
  end

  always_comb begin
    strobe.ldMul     = inValid;
    strobe.ldFold    = validPipe[0];
    strobe.ldOut     = validPipe[1];
    strobe.narrowOut = narrowPipe[1];
  end

  assign outValid = validPipe[PIPE_DEPTH-1];
endmodule

// File: rtl/dualq_datapath.sv
module dualq_datapath
  import dualq_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  stageStrobe_t       strobe,
  input  logic [WORD_W-1:0]  opA,
  input  logic [WORD_W-1:0]  opB,
  output logic [WORD_W-1:0]  result
);
  logic [WIDE_PW-1:0] prodWide;
  logic [LANE_PW-1:0] prodLane [LANES];
  logic [WIDE_FW-1:0] foldWideC, foldWideQ;
  logic [LANE_FW-1:0] foldLaneC [LANES];
  logic [LANE_FW-1:0] foldLaneQ [LANES];
  logic [WORD_W-1:0]  narrowWord;

  // Stage 1: one wide multiply and one multiply per lane.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prodWide <= '0;
    else if (strobe.ldMul)
      prodWide <= WIDE_PW'(opA[WIDE_W-1:0]) * WIDE_PW'(opB[WIDE_W-1:0]);
  end

  dualq_wide_reducer uWide (.prodIn(prodWide), .foldOut(foldWideC));

  generate
    for (genvar g = 0; g < LANES; g++) begin : gLane
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prodLane[g] <= '0;
        else if (strobe.ldMul)
          prodLane[g] <= LANE_PW'(opA[g*LANE_W +: LANE_W]) * LANE_PW'(opB[g*LANE_W +: LANE_W]);
      end

      dualq_lane_reducer uLane (.prodIn(prodLane[g]), .foldOut(foldLaneC[g]));

      // Stage 2: folded lane value.
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) foldLaneQ[g] <= '0;
        else if (strobe.ldFold) foldLaneQ[g] <= foldLaneC[g];
      end

      assign narrowWord[g*LANE_W +: LANE_W] = fixLane(foldLaneQ[g]);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) foldWideQ <= '0;
    else if (strobe.ldFold) foldWideQ <= foldWideC;
  end

  // Stage 3: conditional subtraction and scheme select.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) result <= '0;
    else if (strobe.ldOut)
      result <= strobe.narrowOut ? narrowWord : {1'b0, fixWide(foldWideQ)};
  end
endmodule

// File: rtl/dualq_modmul.sv
module dualq_modmul
  import dualq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inValid,
  input  logic              useNarrow,
  input  logic [WORD_W-1:0] opA,
  input  logic [WORD_W-1:0] opB,
  output logic              outValid,
  output logic [WORD_W-1:0] result
);
  stageStrobe_t strobe;

  dualq_ctrl uCtrl (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .useNarrow(useNarrow),
    .strobe(strobe), .outValid(outValid)
  );

  dualq_datapath uPath (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .opA(opA), .opB(opB),
    .result(result)
  );
endmodule

// File: rtl/dualq_modmul_chk.sv
module dualq_modmul_chk
  import dualq_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              inValid,
  input logic              useNarrow,
  input logic [WORD_W-1:0] opA,
  input logic [WORD_W-1:0] opB,
  input logic              outValid,
  input logic [WORD_W-1:0] result
);
  logic [1:0] upCnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) upCnt <= '0;
    else if (upCnt != 2'd3) upCnt <= upCnt + 2'd1;
  end

  function automatic logic [WORD_W-1:0] refWide(input logic [WORD_W-1:0] a, input logic [WORD_W-1:0] b);
    longint unsigned x, y;
    x = longint'(a[WIDE_W-1:0]);
    y = longint'(b[WIDE_W-1:0]);
    return WORD_W'((x * y) % longint'(WIDE_Q));
  endfunction

  function automatic logic [WORD_W-1:0] refNarrow(input logic [WORD_W-1:0] a, input logic [WORD_W-1:0] b);
    longint unsigned l0, l1;
    l0 = (longint'(a[11:0]) * longint'(b[11:0])) % longint'(LANE_Q);
    l1 = (longint'(a[23:12]) * longint'(b[23:12])) % longint'(LANE_Q);
    return {LANE_W'(l1), LANE_W'(l0)};
  endfunction

  assert_wide_value_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (upCnt == 2'd3 && outValid && !$past(useNarrow, 3))
      |-> result == refWide($past(opA, 3), $past(opB, 3)));

  assert_narrow_value_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (upCnt == 2'd3 && outValid && $past(useNarrow, 3))
      |-> result == refNarrow($past(opA, 3), $past(opB, 3)));

  assert_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (upCnt == 2'd3 && outValid)
      |-> ($past(useNarrow, 3) ? (result[11:0] < LANE_W'(LANE_Q) && result[23:12] < LANE_W'(LANE_Q))
                               : (result < WORD_W'(WIDE_Q))));

  assert_latency_R4: assert property (@(posedge clk) disable iff (!rst_n)
    inValid |-> ##3 outValid);

  assert_no_spurious_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (upCnt == 2'd3 && outValid) |-> $past(inValid, 3));

  assert_early_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (upCnt != 2'd3) |-> !outValid);

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (upCnt != 2'd0 && !outValid) |-> $stable(result));
endmodule

bind dualq_modmul dualq_modmul_chk uChk (
  .clk(clk), .rst_n(rst_n), .inValid(inValid), .useNarrow(useNarrow),
  .opA(opA), .opB(opB), .outValid(outValid), .result(result)
);

// File: tb/sim_dualq_modmul.sv
module sim_dualq_modmul;
  localparam time CLK_PERIOD = 10ns;
  localparam int  NVEC = 12;
  localparam int  QW = 8380417;
  localparam int  QN = 3329;

  // {useNarrow, opA, opB}
  localparam logic [48:0] VEC [NVEC] = '{
    {1'b0, 24'd0,        24'd5},
    {1'b1, {12'd3328, 12'd3328}, {12'd3328, 12'd3328}},
    {1'b0, 24'd8380416,  24'd8380416},
    {1'b1, {12'd0, 12'd1},       {12'd3328, 12'd2}},
    {1'b0, 24'd1,        24'd1},
    {1'b1, {12'd1234, 12'd17},   {12'd2345, 12'd3000}},
    {1'b0, 24'd123456,   24'd7654321},
    {1'b0, 24'd8380416,  24'd2},
    {1'b1, {12'd3328, 12'd0},    {12'd1, 12'd3328}},
    {1'b0, 24'd4190208,  24'd4190209},
    {1'b1, {12'd2048, 12'd4},    {12'd2047, 12'd3327}},
    {1'b0, 24'd8380000,  24'd8379999}
  };

  logic clk = 0, rst_n = 0, inValid = 0, useNarrow = 0;
  logic [23:0] opA = '0, opB = '0;
  logic outValid;
  logic [23:0] result;

  int runCnt = 0, failCnt = 0;
  logic [23:0] expQ [NVEC];
  logic        expNarrow [NVEC];
  int wrIdx = 0, rdIdx = 0;
  bit monOn = 0, done = 0;

  dualq_modmul u0 (.clk(clk), .rst_n(rst_n), .inValid(inValid), .useNarrow(useNarrow),
                   .opA(opA), .opB(opB), .outValid(outValid), .result(result));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [23:0] model(input logic nar, input logic [23:0] a, input logic [23:0] b);
    longint unsigned l0, l1;
    if (nar) begin
      l0 = (longint'(a[11:0]) * longint'(b[11:0])) % QN;
      l1 = (longint'(a[23:12]) * longint'(b[23:12])) % QN;
      return {l1[11:0], l0[11:0]};
    end
    l0 = (longint'(a[22:0]) * longint'(b[22:0])) % QW;
    return l0[23:0];
  endfunction

  task automatic check(input string req, input logic [23:0] act, input logic [23:0] exp);
    runCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Stream monitor: R1/R2/R5 values, R3 range.
  always @(negedge clk) begin
    if (monOn && outValid) begin
      if (rdIdx < NVEC) begin
        check(expNarrow[rdIdx] ? "R2/R5" : "R1/R5", result, expQ[rdIdx]);
        if (expNarrow[rdIdx])
          check("R3", 24'((result[11:0] < 12'd3329) && (result[23:12] < 12'd3329)), 24'd1);
        else
          check("R3", 24'(result < 24'd8380417), 24'd1);
      end else check("R4", 24'(rdIdx), 24'(NVEC - 1));
      rdIdx++;
    end
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      failCnt++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", runCnt, failCnt);
      $finish;
    end
  end

  initial begin
    // R6: reset state
    repeat (3) @(negedge clk);
    check("R6", {23'b0, outValid}, 24'd0);
    check("R6", result, 24'd0);
    rst_n = 1;
    @(negedge clk);
    check("R6", {23'b0, outValid}, 24'd0);

    // Table stream, back to back, schemes interleaved
    monOn = 1;
    for (int i = 0; i < NVEC; i++) begin
      inValid = 1;
      useNarrow = VEC[i][48];
      opA = VEC[i][47:24];
      opB = VEC[i][23:0];
      expQ[wrIdx] = model(VEC[i][48], VEC[i][47:24], VEC[i][23:0]);
      expNarrow[wrIdx] = VEC[i][48];
      wrIdx++;
      @(negedge clk);
    end
    inValid = 0;
    opA = '0; opB = '0;
    repeat (5) @(negedge clk);
    monOn = 0;
    check("R4", 24'(rdIdx), 24'(NVEC));
    check("R1", 24'(expQ[2]), 24'd1);   // (q-1)^2 mod q == 1
    check("R2", 24'(expQ[1]), {12'd1, 12'd1});

    // R7: result held while idle
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R7", result, expQ[NVEC-1]);
    end

    // R4 latency edge by edge, R8 bit 23 ignored in wide scheme
    inValid = 1; useNarrow = 0;
    opA = 24'h800000 | 24'd5; opB = 24'h800000 | 24'd7;
    @(negedge clk);
    inValid = 0; opA = '0; opB = '0;
    check("R4", {23'b0, outValid}, 24'd0);
    @(negedge clk);
    check("R4", {23'b0, outValid}, 24'd0);
    @(negedge clk);
    check("R4", {23'b0, outValid}, 24'd1);
    check("R8", result, 24'd35);
    @(negedge clk);
    check("R4", {23'b0, outValid}, 24'd0);
    check("R7", result, 24'd35);

    // R6: reset clears a held result
    rst_n = 0;
    @(negedge clk);
    check("R6", result, 24'd0);
    check("R6", {23'b0, outValid}, 24'd0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", runCnt, failCnt);
    $finish;
  end
endmodule